// File: doc/BRIEF.md
# Coverage Mask Occupancy Statistics Unit

This block watches a stream of 16-bit coverage masks coming out of a tile rasterizer. Each mask stands for one 4x4 pixel group that starts on a 4-pixel boundary, with one bit per pixel. For each accepted mask the block counts the covered pixels, which is the number of lanes a 16-lane vector shader would have busy. It also counts the 2x2 quads that hold at least one covered pixel, which is what a quad-based shader would process.

Each mask's own pixel and quad counts come out one cycle after it is accepted, with a matching valid flag. Three running totals are kept alongside: masks seen, covered pixels and non-empty quads. Dividing pixels by calls gives vector-lane utilisation. Dividing pixels by quads gives quad utilisation. The totals saturate instead of wrapping. A synchronous clear zeroes them in one cycle. A sticky flag records that an all-zero mask was ever accepted.

Top module: `covmask_occ_stats`

## Requirements
- R1: After reset, all three totals are zero, `stat_vld` is 0 and `empty_seen` is 0.
- R2: Mask bit index is row*4 + column, with row 0 at the top. For a mask accepted at a clock edge (`mask_vld`=1), `stat_vld` is 1 after that edge and `stat_pix` equals the number of set bits of the mask (0 to 16).
- R3: `stat_quads`, valid together with `stat_pix`, is the number of non-zero results among mask AND 0x0033 (top-left), 0x00CC (top-right), 0x3300 (bottom-left) and 0xCC00 (bottom-right), a value from 0 to 4.
- R4: Each accepted mask, the all-zero mask included, adds one to `tot_calls`.
- R5: `tot_pix` and `tot_quads` add the mask's pixel count and quad count. The new totals are visible after the same edge that accepts the mask, and back-to-back masks all accumulate.
- R6: When `mask_vld` is 0, the value on `mask_in` is ignored: no total changes and `stat_vld` is 0 after the edge.
- R7: An accepted all-zero mask gives `stat_pix`=0 and `stat_quads`=0 and sets `empty_seen`. `empty_seen` stays 1 until clear or reset.
- R8: Each total saturates at 2^CNT_W-1 and never wraps.
- R9: With `clr`=1, all totals and `empty_seen` are 0 after the edge. Clear takes priority over a mask accepted in the same cycle: that mask is left out of the totals, but its per-mask outputs are still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of totals and empty flag |
| mask_vld | input | 1 | Mask on `mask_in` is accepted this cycle |
| mask_in | input | 16 | Coverage mask, bit = row*4 + column |
| stat_vld | output | 1 | Per-mask outputs valid |
| stat_pix | output | 5 | Covered pixels of the last accepted mask |
| stat_quads | output | 3 | Non-empty quads of the last accepted mask |
| tot_calls | output | CNT_W | Accepted masks |
| tot_pix | output | CNT_W | Sum of covered pixels |
| tot_quads | output | CNT_W | Sum of non-empty quads |
| empty_seen | output | 1 | Sticky: an all-zero mask was accepted |

## Verification
The tests use these masks:
- A full mask and a single-pixel mask, which fix the two ends of the pixel range.
- Masks that fill exactly one quad, a diagonal, and a centred 2x2 that touches all four quads. These separate the quad count from the pixel count and check each quad's bit positions.
- An empty mask, which checks the sticky flag.
- A back-to-back stream that changes every cycle, which checks that the one-cycle latency lines up with accumulation.
- A mask held on the input with valid low, clear arriving alone and together with a mask, and a long run of full masks with a narrow counter. These cover ignoring, clear priority and saturation.

// File: rtl/covmask_pkg.sv
package covmask_pkg;

    localparam int MASK_W  = 16;
    localparam int SIDE    = 4;
    localparam int NQUAD   = 4;
    localparam int PIX_W   = $clog2(MASK_W + 1);
    localparam int QUAD_W  = $clog2(NQUAD + 1);

    typedef logic [MASK_W-1:0] cov_mask_t;

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [QUAD_W-1:0] quads;
    } mask_stat_t;

    // Sub-mask of quad q: q[0] picks the column pair, q[1] picks the row pair.
    function automatic cov_mask_t quad_sel(input int q);
        cov_mask_t m;
        int qr;
        int qc;
        m  = '0;
        qr = q / 2;
        qc = q % 2;
        for (int dr = 0; dr < 2; dr++) begin
            for (int dc = 0; dc < 2; dc++) begin
                m[(2*qr + dr)*SIDE + 2*qc + dc] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic logic [PIX_W-1:0] count_ones(input cov_mask_t m);
        logic [PIX_W-1:0] c;
        c = '0;
        for (int i = 0; i < MASK_W; i++) begin
            c = c + {{(PIX_W-1){1'b0}}, m[i]};
        end
        return c;
    endfunction

endpackage

// File: rtl/covmask_popcnt.sv
module covmask_popcnt
    import covmask_pkg::*;
(
    input  cov_mask_t          mask,
    output logic [PIX_W-1:0]   pix
);
    always_comb begin
        pix = count_ones(mask);
    end
endmodule

// File: rtl/covmask_quads.sv
module covmask_quads
    import covmask_pkg::*;
(
    input  cov_mask_t           mask,
    output logic [QUAD_W-1:0]   quads
);
    logic [NQUAD-1:0] hit;

    for (genvar q = 0; q < NQUAD; q++) begin : g_quad
        assign hit[q] = |(mask & quad_sel(q));
    end

    always_comb begin
        quads = '0;
        for (int q = 0; q < NQUAD; q++) begin
            quads = quads + {{(QUAD_W-1){1'b0}}, hit[q]};
        end
    end
endmodule

// File: rtl/covmask_satcnt.sv
module covmask_satcnt #(
    parameter int W     = 32,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, cnt} + {{(W+1-INC_W){1'b0}}, inc};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (add_en) begin
            cnt <= sum[W] ? CMAX : sum[W-1:0];
        end
    end

    // R9: clear empties the counter on the next edge
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R8: without clear the count never goes down, so it cannot wrap
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

    // R8: a full counter stays full
    p_hold_max_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == CMAX) |=> (cnt == CMAX));
endmodule

// File: rtl/covmask_occ_stats.sv
module covmask_occ_stats
    import covmask_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              mask_vld,
    input  logic [15:0]       mask_in,
    output logic              stat_vld,
    output logic [4:0]        stat_pix,
    output logic [2:0]        stat_quads,
    output logic [CNT_W-1:0]  tot_calls,
    output logic [CNT_W-1:0]  tot_pix,
    output logic [CNT_W-1:0]  tot_quads,
    output logic              empty_seen
);
    mask_stat_t cur;
    mask_stat_t held;
    logic       accept;

    covmask_popcnt u_pop (
        .mask (mask_in),
        .pix  (cur.pix)
    );

    covmask_quads u_quad (
        .mask  (mask_in),
        .quads (cur.quads)
    );

    assign accept = mask_vld && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_vld <= 1'b0;
            held     <= '0;
        end else begin
            stat_vld <= mask_vld;
            if (mask_vld) begin
                held <= cur;
            end
        end
    end

    assign stat_pix   = held.pix;
    assign stat_quads = held.quads;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            empty_seen <= 1'b0;
        end else if (mask_vld && mask_in == '0) begin
            empty_seen <= 1'b1;
        end
    end

    covmask_satcnt #(.W(CNT_W), .INC_W(1)) u_calls (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .add_en (accept),
        .inc    (1'b1),
        .cnt    (tot_calls)
    );

    covmask_satcnt #(.W(CNT_W), .INC_W(PIX_W)) u_pix (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .add_en (accept),
        .inc    (cur.pix),
        .cnt    (tot_pix)
    );

    covmask_satcnt #(.W(CNT_W), .INC_W(QUAD_W)) u_qd (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .add_en (accept),
        .inc    (cur.quads),
        .cnt    (tot_quads)
    );

    // R2: one-cycle latency of the per-mask valid
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        mask_vld |=> stat_vld);

    // R6: no valid in, no valid out
    p_idle_out_r6: assert property (@(posedge clk) disable iff (rst)
        !mask_vld |=> !stat_vld);

    // R6: idle cycles leave the totals alone
    p_idle_tot_r6: assert property (@(posedge clk) disable iff (rst)
        (!mask_vld && !clr) |=> ($stable(tot_calls) && $stable(tot_pix) && $stable(tot_quads)));

    // R3: a quad needs at least one pixel, so quads never exceed pixels
    p_quads_le_pix_r3: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> ({2'b00, stat_quads} <= stat_pix));

    // R7: an empty mask reports no quads and has set the flag
    p_empty_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_vld && stat_pix == '0) |-> (stat_quads == '0 && (empty_seen || $past(clr))));

    // R7: the flag only drops on clear
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (empty_seen && !clr) |=> empty_seen);
endmodule

// File: tb/sim_covmask_occ_stats.sv
module sim_covmask_occ_stats;
    localparam int W = 12;
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic clk = 1'b0;
    logic rst, clr, mask_vld;
    logic [15:0] mask_in;
    logic stat_vld, empty_seen;
    logic [4:0] stat_pix;
    logic [2:0] stat_quads;
    logic [W-1:0] tot_calls, tot_pix, tot_quads;

    int checks = 0;
    int errors = 0;
    int e_calls, e_pix, e_quads;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    covmask_occ_stats #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .clr(clr), .mask_vld(mask_vld), .mask_in(mask_in),
        .stat_vld(stat_vld), .stat_pix(stat_pix), .stat_quads(stat_quads),
        .tot_calls(tot_calls), .tot_pix(tot_pix), .tot_quads(tot_quads),
        .empty_seen(empty_seen)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 50000", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_pix(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) if (m[i]) c++;
        return c;
    endfunction

    function automatic int ref_quads(input logic [15:0] m);
        int c = 0;
        if ((m & 16'h0033) != 0) c++;
        if ((m & 16'h00CC) != 0) c++;
        if ((m & 16'h3300) != 0) c++;
        if ((m & 16'hCC00) != 0) c++;
        return c;
    endfunction

    function automatic int satw(input int v);
        return (v > int'(CMAX)) ? int'(CMAX) : v;
    endfunction

    task automatic check_tots(input string req);
        chk({req, " calls"}, int'(tot_calls), satw(e_calls));
        chk({req, " pix"},   int'(tot_pix),   satw(e_pix));
        chk({req, " quads"}, int'(tot_quads), satw(e_quads));
    endtask

    // Inputs change at negedge; outputs are read at the following negedge.
    task automatic send(input logic [15:0] m, input string req);
        mask_vld = 1'b1; mask_in = m;
        @(negedge clk);
        mask_vld = 1'b0;
        e_calls += 1; e_pix += ref_pix(m); e_quads += ref_quads(m);
        chk({req, " vld"},   int'(stat_vld),   1);
        chk({req, " pix"},   int'(stat_pix),   ref_pix(m));
        chk({req, " quads"}, int'(stat_quads), ref_quads(m));
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        e_calls = 0; e_pix = 0; e_quads = 0;
    endtask

    task automatic t_reset();
        chk("R1 vld", int'(stat_vld), 0);
        chk("R1 empty", int'(empty_seen), 0);
        check_tots("R1");
    endtask

    task automatic t_patterns();
        send(16'hFFFF, "R2 full");
        send(16'h0001, "R2 single");
        send(16'h0033, "R3 tl");
        send(16'h00CC, "R3 tr");
        send(16'h3300, "R3 bl");
        send(16'hCC00, "R3 br");
        send(16'h8421, "R3 diag");
        send(16'h0660, "R3 centre");
        send(16'h1000, "R3 corner");
        check_tots("R4 R5 single");
        chk("R7 not set", int'(empty_seen), 0);
    endtask

    task automatic t_stream();
        logic [15:0] seq [6] = '{16'h0F0F, 16'h00C0, 16'h8001, 16'h7FFE, 16'h0300, 16'h0002};
        for (int i = 0; i < 6; i++) begin
            send(seq[i], "R5 stream");
        end
        check_tots("R5 stream");
    endtask

    task automatic t_idle();
        mask_vld = 1'b0; mask_in = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        chk("R6 vld", int'(stat_vld), 0);
        check_tots("R6 idle");
    endtask

    task automatic t_empty();
        send(16'h0000, "R7 empty");
        chk("R7 flag", int'(empty_seen), 1);
        check_tots("R4 empty call");
        send(16'h0101, "R7 after");
        chk("R7 sticky", int'(empty_seen), 1);
    endtask

    task automatic t_clear();
        do_clear();
        check_tots("R9 clear");
        chk("R9 flag", int'(empty_seen), 0);
        send(16'h0033, "R9 pre");
        clr = 1'b1; mask_vld = 1'b1; mask_in = 16'hFFFF;
        @(negedge clk);
        clr = 1'b0; mask_vld = 1'b0;
        e_calls = 0; e_pix = 0; e_quads = 0;
        chk("R9 prio vld", int'(stat_vld), 1);
        chk("R9 prio pix", int'(stat_pix), 16);
        check_tots("R9 prio");
    endtask

    task automatic t_saturate();
        do_clear();
        mask_vld = 1'b1; mask_in = 16'hFFFF;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            e_calls += 1; e_pix += 16; e_quads += 4;
        end
        mask_vld = 1'b0;
        chk("R8 pix max", int'(tot_pix), int'(CMAX));
        check_tots("R8 sat");
        send(16'h0001, "R8 more");
        chk("R8 still max", int'(tot_pix), int'(CMAX));
    endtask

    initial begin
        rst = 1'b1; clr = 1'b0; mask_vld = 1'b0; mask_in = '0;
        e_calls = 0; e_pix = 0; e_quads = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_stream();
        t_idle();
        t_empty();
        t_clear();
        t_saturate();
        done = 1;
        summary();
    end
endmodule